// File: doc/BRIEF.md
# Divergent Warp Merger

After a divergent branch, warps reach the issue stage with only some SIMD lanes active. This block keeps a small pool of such partial warps. It compares every arriving partial warp against all pool entries in one cycle. When an entry holds the same program counter and has no active lane in common with the newcomer, the two are fused into one warp. Each thread keeps its home lane, because its registers live in that lane. A fused warp that fills every lane goes to issue at once. Otherwise the fused warp stays in the pool in place of the old entry.

A warp that arrives with every lane active skips the pool. A warp that matches nothing takes a free slot. If no slot is free, it goes to issue unchanged. Each entry carries an age counter. An entry that has waited a set number of cycles is sent out as it is, so a partial warp cannot wait forever for a partner. The output port carries at most one warp per cycle and is registered. Warps derived from the input of a cycle have priority over aged entries.

Top module: `warp_merger`

## Requirements
- R1: After reset the pool is empty and `out_valid` is low. With no input, nothing is emitted for any length of time.
- R2: An input whose mask has every lane set appears on the output one cycle later. Its PC, mask and thread IDs are unchanged, and the pool is not touched.
- R3: An input merges with a pool entry only when both PCs are equal and the bitwise AND of the two masks is zero.
- R4: A merged warp has the OR of both masks. For each lane, the thread ID comes from whichever side has that lane active. Lane l occupies bits [l*TID_W +: TID_W] of the thread-ID vector.
- R5: If a merge fills every lane, the merged warp is emitted on the next cycle and its pool slot is freed.
- R6: A partial input with no compatible entry is stored in the lowest-index free slot. Storing it produces no output.
- R7: An entry is emitted unchanged `MAX_AGE+1` cycles after it was stored, provided the output is free. A partial merge does not restart this count.
- R8: When several entries are compatible, the input merges with the lowest-index one.
- R9: When no entry is compatible and every slot is occupied, the input is emitted unchanged on the next cycle.
- R10: An input with an all-zero mask is ignored. It neither emits nor stores anything.
- R11: In every emitted warp, the thread-ID field of each inactive lane is zero.
- R12: If an input needs the output in the same cycle that an entry ages out, the input's warp goes first. The aged entry follows on the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming partial warp present |
| in_pc | input | PC_W | Program counter of the incoming warp |
| in_mask | input | LANES | Active-lane mask of the incoming warp |
| in_tids | input | LANES*TID_W | Per-lane thread IDs, lane 0 in the low bits |
| out_valid | output | 1 | Warp sent to issue this cycle |
| out_pc | output | PC_W | Program counter of the emitted warp |
| out_mask | output | LANES | Active-lane mask of the emitted warp |
| out_tids | output | LANES*TID_W | Per-lane thread IDs, inactive lanes zero |

## Verification
The bench covers four kinds of incompatible pair:
- Two warps at the same PC whose masks overlap in a single lane. A design that tested only PC equality would fuse them and drop a thread.
- A PC mismatch with disjoint masks. Here the mismatch alone must prevent the merge.
- Two compatible entries with different lane-0 threads. If the design picked the wrong slot, the lane-0 thread ID in the output would be wrong.
- A full pool. A design that dropped the input there would emit nothing.

Aging is checked to the exact cycle, including a partial merge in the middle of the wait, which a design resetting the age would delay. A collision between a bypass and an expiring entry must emit both, in order. Garbage in inactive lanes must show up as zeros at the output.

// File: rtl/warp_merger.sv
module warp_merger #(
  parameter int LANES   = 4,
  parameter int POOL    = 8,
  parameter int PC_W    = 16,
  parameter int TID_W   = 8,
  parameter int MAX_AGE = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [PC_W-1:0]        in_pc,
  input  logic [LANES-1:0]       in_mask,
  input  logic [LANES*TID_W-1:0] in_tids,
  output logic                   out_valid,
  output logic [PC_W-1:0]        out_pc,
  output logic [LANES-1:0]       out_mask,
  output logic [LANES*TID_W-1:0] out_tids
);
  localparam int IW = (POOL > 1) ? $clog2(POOL) : 1;
  localparam int AW = $clog2(MAX_AGE + 1);
  localparam logic [AW-1:0] AGE_LIM = AW'(MAX_AGE);
  localparam int TW = LANES * TID_W;

  logic            v_q    [POOL];
  logic [PC_W-1:0] pc_q   [POOL];
  logic [LANES-1:0] mask_q[POOL];
  logic [TW-1:0]   tid_q  [POOL];
  logic [AW-1:0]   age_q  [POOL];

  logic [POOL-1:0] hit, free, aged, ev_cand;
  logic [IW-1:0]   hit_idx, free_idx, ev_idx;
  logic            hit_any, free_any;

  for (genvar i = 0; i < POOL; i++) begin : g_cmp
    assign hit[i]  = v_q[i] && (pc_q[i] == in_pc) && ((mask_q[i] & in_mask) == '0);
    assign free[i] = !v_q[i];
    assign aged[i] = v_q[i] && (age_q[i] == AGE_LIM);
  end

  always_comb begin
    hit_idx = '0;
    free_idx = '0;
    for (int i = POOL - 1; i >= 0; i--) begin
      if (hit[i])  hit_idx  = IW'(i);
      if (free[i]) free_idx = IW'(i);
    end
  end
  assign hit_any  = |hit;
  assign free_any = |free;

  logic in_act, in_full, bypass, do_merge, merge_full, do_alloc, overflow, in_out, do_evict;
  assign in_act     = in_valid && (|in_mask);
  assign in_full    = &in_mask;
  assign bypass     = in_act && in_full;
  assign do_merge   = in_act && !in_full && hit_any;
  assign do_alloc   = in_act && !in_full && !hit_any && free_any;
  assign overflow   = in_act && !in_full && !hit_any && !free_any;

  logic [LANES-1:0] mrg_mask;
  logic [TW-1:0]    mrg_tids, in_tids_m;
  assign mrg_mask   = mask_q[hit_idx] | in_mask;
  assign merge_full = do_merge && (&mrg_mask);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign in_tids_m[l*TID_W +: TID_W] = in_mask[l] ? in_tids[l*TID_W +: TID_W] : '0;
    assign mrg_tids[l*TID_W +: TID_W]  = in_mask[l] ? in_tids[l*TID_W +: TID_W]
                                                    : tid_q[hit_idx][l*TID_W +: TID_W];
  end

  assign in_out   = bypass || merge_full || overflow;
  assign ev_cand  = aged & ~(do_merge ? (POOL'(1) << hit_idx) : '0);
  assign do_evict = !in_out && (|ev_cand);

  always_comb begin
    ev_idx = '0;
    for (int i = POOL - 1; i >= 0; i--)
      if (ev_cand[i]) ev_idx = IW'(i);
  end

  for (genvar i = 0; i < POOL; i++) begin : g_slot
    logic [AW-1:0] age_nx;
    assign age_nx = (age_q[i] == AGE_LIM) ? age_q[i] : age_q[i] + 1'b1;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[i]    <= 1'b0;
        pc_q[i]   <= '0;
        mask_q[i] <= '0;
        tid_q[i]  <= '0;
        age_q[i]  <= '0;
      end else if (do_alloc && free_idx == IW'(i)) begin
        v_q[i]    <= 1'b1;
        pc_q[i]   <= in_pc;
        mask_q[i] <= in_mask;
        tid_q[i]  <= in_tids_m;
        age_q[i]  <= '0;
      end else if (do_merge && hit_idx == IW'(i)) begin
        v_q[i]    <= !merge_full;
        mask_q[i] <= mrg_mask;
        tid_q[i]  <= mrg_tids;
        age_q[i]  <= age_nx;
      end else if (do_evict && ev_idx == IW'(i)) begin
        v_q[i]    <= 1'b0;
      end else if (v_q[i]) begin
        age_q[i]  <= age_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pc    <= '0;
      out_mask  <= '0;
      out_tids  <= '0;
    end else begin
      out_valid <= in_out || do_evict;
      if (bypass || overflow) begin
        out_pc   <= in_pc;
        out_mask <= in_mask;
        out_tids <= in_tids_m;
      end else if (merge_full) begin
        out_pc   <= in_pc;
        out_mask <= mrg_mask;
        out_tids <= mrg_tids;
      end else if (do_evict) begin
        out_pc   <= pc_q[ev_idx];
        out_mask <= mask_q[ev_idx];
        out_tids <= tid_q[ev_idx];
      end
    end
  end

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&in_mask)) |=> (out_valid && (&out_mask) && out_pc == $past(in_pc)
                                  && out_tids == $past(in_tids)));

  // R10
  out_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (|out_mask));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R11
    idle_lane_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_mask[l]) |-> (out_tids[l*TID_W +: TID_W] == '0));
  end

  for (genvar i = 0; i < POOL; i++) begin : g_slot_chk
    // R5
    slot_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[i] |-> ((|mask_q[i]) && !(&mask_q[i])));
    for (genvar j = i + 1; j < POOL; j++) begin : g_pair
      // R3
      no_mergeable_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q[i] && v_q[j] && pc_q[i] == pc_q[j]) |-> ((mask_q[i] & mask_q[j]) != '0));
    end
  end
endmodule

// File: tb/tb_warp_merger.sv
module tb_warp_merger;
  localparam int CLK_P = 10;
  localparam int AGE   = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_pc = '0;
  logic [3:0]  in_mask = '0;
  logic [31:0] in_tids = '0;
  logic        out_valid;
  logic [15:0] out_pc;
  logic [3:0]  out_mask;
  logic [31:0] out_tids;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  warp_merger #(.LANES(4), .POOL(8), .PC_W(16), .TID_W(8), .MAX_AGE(AGE)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc), .in_mask(in_mask),
    .in_tids(in_tids), .out_valid(out_valid), .out_pc(out_pc), .out_mask(out_mask),
    .out_tids(out_tids));

  function automatic logic [31:0] tv(input int t3, input int t2, input int t1, input int t0);
    return {8'(t3), 8'(t2), 8'(t1), 8'(t0)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_none(input string req);
    chk(req, 64'(out_valid), 64'd0);
  endtask

  task automatic expect_out(input string req, input logic [15:0] pc, input logic [3:0] m,
                            input logic [31:0] t);
    chk(req, {11'd0, out_valid, out_pc, out_mask, out_tids}, {11'd0, 1'b1, pc, m, t});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [15:0] pc, input logic [3:0] m, input logic [31:0] t);
    @(negedge clk);
    in_valid = 1'b1;
    in_pc = pc;
    in_mask = m;
    in_tids = t;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    expect_none("R1");
    for (int k = 0; k < AGE + 3; k++) begin
      step();
      if (out_valid) expect_none("R1");
    end
    expect_none("R1");
  endtask

  task automatic t_bypass();
    do_reset();
    send(16'h0010, 4'b1111, tv(3, 2, 1, 0));
    expect_out("R2", 16'h0010, 4'b1111, tv(3, 2, 1, 0));
    step();
    expect_none("R2");
  endtask

  task automatic t_merge_pair();
    do_reset();
    send(16'h0020, 4'b0011, tv(85, 85, 1, 0));
    expect_none("R6");
    send(16'h0020, 4'b1100, tv(7, 6, 170, 170));
    expect_out("R4 R5", 16'h0020, 4'b1111, tv(7, 6, 1, 0));
    for (int k = 0; k < AGE + 3; k++) begin
      step();
      if (out_valid) expect_none("R5");
    end
    expect_none("R5");
  endtask

  task automatic t_partial_age();
    do_reset();
    send(16'h0030, 4'b0001, tv(99, 99, 99, 8));
    for (int n = 1; n <= 3; n++) step();
    send(16'h0030, 4'b0100, tv(77, 10, 77, 77));
    expect_none("R3");
    for (int n = 5; n <= AGE; n++) begin
      step();
      if (out_valid) expect_none("R7");
    end
    expect_none("R7");
    step();
    expect_out("R7 R11", 16'h0030, 4'b0101, tv(0, 10, 0, 8));
  endtask

  task automatic t_conflict();
    do_reset();
    send(16'h0040, 4'b0011, tv(0, 0, 1, 0));
    send(16'h0041, 4'b1100, tv(3, 2, 0, 0));
    expect_none("R3");
    send(16'h0040, 4'b0110, tv(0, 5, 4, 0));
    expect_none("R3");
    send(16'h0040, 4'b1100, tv(7, 6, 0, 0));
    expect_out("R3 R8", 16'h0040, 4'b1111, tv(7, 6, 1, 0));
    for (int n = 4; n <= AGE + 1; n++) begin
      step();
      if (out_valid) expect_none("R6");
    end
    step();
    expect_out("R6 R7", 16'h0041, 4'b1100, tv(3, 2, 0, 0));
    step();
    expect_out("R6 R7", 16'h0040, 4'b0110, tv(0, 5, 4, 0));
  endtask

  task automatic t_lowest();
    do_reset();
    send(16'h0050, 4'b0001, tv(0, 0, 0, 0));
    send(16'h0050, 4'b0001, tv(0, 0, 0, 4));
    expect_none("R6");
    send(16'h0050, 4'b1110, tv(3, 2, 1, 0));
    expect_out("R8", 16'h0050, 4'b1111, tv(3, 2, 1, 0));
  endtask

  task automatic t_overflow();
    do_reset();
    for (int s = 0; s < 8; s++) send(16'h0060 + 16'(s), 4'b0001, tv(0, 0, 0, s));
    expect_none("R6");
    send(16'h0070, 4'b0010, tv(55, 55, 9, 55));
    expect_out("R9 R11", 16'h0070, 4'b0010, tv(0, 0, 9, 0));
    send(16'h0060, 4'b0010, tv(0, 0, 1, 0));
    expect_none("R9");
  endtask

  task automatic t_zero();
    do_reset();
    send(16'h0080, 4'b0000, tv(1, 2, 3, 4));
    expect_none("R10");
    for (int k = 0; k < AGE + 3; k++) begin
      step();
      if (out_valid) expect_none("R10");
    end
    expect_none("R10");
  endtask

  task automatic t_priority();
    do_reset();
    send(16'h0090, 4'b0001, tv(0, 0, 0, 12));
    for (int n = 1; n <= AGE; n++) step();
    expect_none("R12");
    send(16'h0091, 4'b1111, tv(4, 3, 2, 1));
    expect_out("R12", 16'h0091, 4'b1111, tv(4, 3, 2, 1));
    step();
    expect_out("R12", 16'h0090, 4'b0001, tv(0, 0, 0, 12));
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_merge_pair();
    t_partial_age();
    t_conflict();
    t_lowest();
    t_overflow();
    t_zero();
    t_priority();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule